// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block holds a bank of 32-bit system control words behind a single-cycle, word-addressed register port with separate read and write strobes. A dedicated key word gates the lower part of the bank. Writing the right magic value there marks the bank as open, and any other value closes it. A write into the protected window while the bank is closed is still carried out, but it raises a lock-violation pulse so that the system can notice the access.

A few words have special write behaviour. The hardware strap word can only gain bits through its own address. Its bits can only be cleared through the revision word's address, and that address otherwise reads the fixed revision value. A fixed set of identity, scratch and status words is visible but cannot be written: a write there is discarded and raises an error pulse. Addresses beyond the implemented bank read as zero and raise the same error pulse. Only aligned 32-bit accesses exist, because the port carries a word index, and data is little-endian.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, reads return 0x1234ABCD at word 16, 0x88884444 at word 17, 0x00001903 at word 20, 0x0000007B at word 21, the parameter REV_WORD (default 0x0A0B0001) at word 2, and 0 at every other in-range word, including the key word 0.
- R2: A write to word 0 records 1 when the data equals the parameter KEY (default 0x1688A8A8) and 0 for any other data. A read of word 0 returns that bit in bit 0, with bits 31:1 at zero.
- R3: A write to the strap word 1 ORs the write data into its current value.
- R4: A write to word 2 clears the strap bits that are 1 in the write data. The value read at word 2 is unchanged and no error pulse is raised.
- R5: Words 3, 4 through 11, 12, 13, 14, 16 and 17 are read-only. A write there leaves the stored value unchanged and sets err_pulse high for exactly the cycle after the write.
- R6: An access with a word index at or above NUM_REGS (default 96) writes nothing. A read there returns 0. Either kind of access sets err_pulse for the following cycle. Index NUM_REGS-1 behaves as a normal word.
- R7: A write to words 1 through LOCK_END-1 (default 63) while the key bit is 0 sets lock_viol for the following cycle, and the write still takes effect. Writes to word 0, to words at or above LOCK_END, or made while the key bit is 1 leave lock_viol low.
- R8: A write to any in-range word without special handling stores all 32 data bits unchanged.
- R9: rd_data shows the addressed word in the cycle after rd_en and holds its value while rd_en is low. A read and a write in the same cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_addr | input | ADDR_W | Word index of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| err_pulse | output | 1 | One-cycle pulse for an access out of range or a write to a read-only word |
| lock_viol | output | 1 | One-cycle pulse for a protected write made while the bank is closed |

## Verification
Every word can be read back, so a corrupted internal value shows up on rd_data in the cycle after the next read of that word. A wrong key bit has two visible effects: word 0 reads back wrongly, and lock_viol is wrong on the very next protected write. A wrong address classification gives a wrong err_pulse or lock_viol one cycle after the access, or shows up as a strap or read-only word that changes when it should not. The stimulus reads each affected word back right after touching it, so each fault is exposed within two cycles of its cause.

// File: rtl/sysctl_pkg.sv
// Shared definitions for the system control register bank: the word map,
// the kind of each word, and the reset value of each word.
// Assumes the bank holds at least 22 words, so every mapped word exists.
package sysctl_pkg;

    localparam int IDX_KEY    = 0;
    localparam int IDX_STRAP  = 1;
    localparam int IDX_REV    = 2;
    localparam int IDX_FREQ   = 3;
    localparam int IDX_SCR_LO = 4;
    localparam int IDX_SCR_HI = 11;
    localparam int IDX_RNG    = 12;
    localparam int IDX_CNT    = 13;
    localparam int IDX_CNTX   = 14;
    localparam int IDX_ID0    = 16;
    localparam int IDX_ID1    = 17;
    localparam int IDX_UART   = 20;
    localparam int IDX_PCIE   = 21;

    typedef enum logic [2:0] {
        K_PLAIN    = 3'd0,
        K_KEY      = 3'd1,
        K_STRAP    = 3'd2,
        K_REVALIAS = 3'd3,
        K_RO       = 3'd4,
        K_OOR      = 3'd5
    } kind_e;

    // Classify an in-range word index by its write behaviour.
    function automatic kind_e kind_of(int idx);
        if (idx == IDX_KEY)        return K_KEY;
        else if (idx == IDX_STRAP) return K_STRAP;
        else if (idx == IDX_REV)   return K_REVALIAS;
        else if (idx == IDX_FREQ || (idx >= IDX_SCR_LO && idx <= IDX_SCR_HI) ||
                 idx == IDX_RNG || idx == IDX_CNT || idx == IDX_CNTX ||
                 idx == IDX_ID0 || idx == IDX_ID1)
            return K_RO;
        else
            return K_PLAIN;
    endfunction

    // Give the value a word takes at reset.
    function automatic logic [31:0] reset_word(int idx, logic [31:0] rev);
        case (idx)
            IDX_REV:  return rev;
            IDX_ID0:  return 32'h1234ABCD;
            IDX_ID1:  return 32'h88884444;
            IDX_UART: return 32'h00001903;
            IDX_PCIE: return 32'h0000007B;
            default:  return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Address classifier: maps a word index to its kind, and flags any index
// at or beyond the bank size as out of range. Purely combinational.
module sysctl_decode #(
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 96
) (
    input  logic [ADDR_W-1:0]  addr,
    output sysctl_pkg::kind_e  kind
);
    import sysctl_pkg::*;

    localparam logic [ADDR_W:0] BANK_END = (ADDR_W+1)'(NUM_REGS);

    // Range check first, then the per-word kind.
    always_comb begin
        if ({1'b0, addr} >= BANK_END) kind = K_OOR;
        else                          kind = kind_of(int'(addr));
    end
endmodule

// File: rtl/sysctl_keylock.sv
// Key state and lock-violation detection. Holds the open/closed bit written
// through word 0, and pulses lock_viol one cycle after a write into the
// protected window (words 1 to LOCK_END-1) made while the bank is closed.
// Assumes LOCK_END does not exceed the bank size.
module sysctl_keylock #(
    parameter int          ADDR_W   = 7,
    parameter int          LOCK_END = 64,
    parameter logic [31:0] KEY      = 32'h1688A8A8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              key_hit,
    output logic              key_open,
    output logic              lock_viol
);
    localparam logic [ADDR_W:0] WIN_END = (ADDR_W+1)'(LOCK_END);

    logic in_window;

    // The protected window excludes the key word itself.
    always_comb in_window = (wr_addr != '0) && ({1'b0, wr_addr} < WIN_END);

    // Key bit: the last key write decides it, set only by an exact match.
    always_ff @(posedge clk) begin
        if (!rst_n)                 key_open <= 1'b0;
        else if (wr_en && key_hit)  key_open <= (wr_data == KEY);
    end

    // One-cycle violation pulse for a protected write while closed.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_viol <= 1'b0;
        else        lock_viol <= wr_en && in_window && !key_open;
    end
endmodule

// File: rtl/sysctl_store.sv
// Word storage. Plain words take full write data. The strap word ORs data
// in through its own address and clears bits through the revision alias.
// Read-only words and the key slot hold their reset constant here, and the
// key bit itself lives in the keylock block.
// Assumes wr_kind comes from the decoder for the same wr_addr.
module sysctl_store #(
    parameter int          ADDR_W   = 7,
    parameter int          NUM_REGS = 96,
    parameter logic [31:0] REV_WORD = 32'h0A0B0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  sysctl_pkg::kind_e  wr_kind,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    output logic [31:0]        word_q [NUM_REGS]
);
    import sysctl_pkg::*;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        localparam kind_e             KIND = kind_of(i);
        localparam logic [31:0]       INIT = reset_word(i, REV_WORD);
        localparam logic [ADDR_W-1:0] MY   = ADDR_W'(i);

        if (KIND == K_PLAIN) begin : g_rw
            logic [31:0] q;
            // Plain word: reset constant, then whole-word writes.
            always_ff @(posedge clk) begin
                if (!rst_n)                                         q <= INIT;
                else if (wr_en && wr_kind == K_PLAIN && wr_addr == MY) q <= wr_data;
            end
            assign word_q[i] = q;
        end else if (KIND == K_STRAP) begin : g_strap
            logic [31:0] q;
            // Strap word: set through its own address, clear through the alias.
            always_ff @(posedge clk) begin
                if (!rst_n)                                 q <= INIT;
                else if (wr_en && wr_kind == K_STRAP)       q <= q | wr_data;
                else if (wr_en && wr_kind == K_REVALIAS)    q <= q & ~wr_data;
            end
            assign word_q[i] = q;
        end else begin : g_fixed
            assign word_q[i] = INIT;
        end
    end
endmodule

// File: rtl/sysctl_regbank.sv
// Top of the key-protected system control register bank. One access per
// cycle on a word-indexed port: the write takes effect at the clock edge,
// and read data plus the error and violation pulses are registered there.
// Assumes NUM_REGS >= 22, LOCK_END <= NUM_REGS and 2**ADDR_W > NUM_REGS.
module sysctl_regbank #(
    parameter int          ADDR_W   = 7,
    parameter int          NUM_REGS = 96,
    parameter int          LOCK_END = 64,
    parameter logic [31:0] KEY      = 32'h1688A8A8,
    parameter logic [31:0] REV_WORD = 32'h0A0B0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              err_pulse,
    output logic              lock_viol
);
    import sysctl_pkg::*;

    kind_e       kind;
    logic        key_open;
    logic [31:0] word_q [NUM_REGS];

    sysctl_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
        .addr (req_addr),
        .kind (kind)
    );

    sysctl_keylock #(.ADDR_W(ADDR_W), .LOCK_END(LOCK_END), .KEY(KEY)) u_keylock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (req_addr),
        .wr_data   (wr_data),
        .key_hit   (kind == K_KEY),
        .key_open  (key_open),
        .lock_viol (lock_viol)
    );

    sysctl_store #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .REV_WORD(REV_WORD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_kind (kind),
        .wr_addr (req_addr),
        .wr_data (wr_data),
        .word_q  (word_q)
    );

    // Read port: zero out of range, the key bit at word 0, else stored word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en) begin
            if (kind == K_OOR)      rd_data <= '0;
            else if (kind == K_KEY) rd_data <= {31'b0, key_open};
            else                    rd_data <= word_q[req_addr];
        end
    end

    // Error pulse: out-of-range access or write to a read-only word.
    always_ff @(posedge clk) begin
        if (!rst_n) err_pulse <= 1'b0;
        else        err_pulse <= ((wr_en || rd_en) && kind == K_OOR) ||
                                 (wr_en && kind == K_RO);
    end
endmodule

// File: rtl/sysctl_regbank_chk.sv
// Port-level properties of the register bank, bound to every instance.
// Observes only the ports of the top module.
module sysctl_regbank_chk #(
    parameter int ADDR_W   = 7,
    parameter int NUM_REGS = 96,
    parameter int LOCK_END = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] req_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       rd_data,
    input logic              err_pulse,
    input logic              lock_viol
);
    localparam logic [ADDR_W:0]   BANK_END = (ADDR_W+1)'(NUM_REGS);
    localparam logic [ADDR_W:0]   WIN_END  = (ADDR_W+1)'(LOCK_END);
    localparam logic [ADDR_W-1:0] A_ID0    = ADDR_W'(sysctl_pkg::IDX_ID0);
    localparam logic [ADDR_W-1:0] A_REV    = ADDR_W'(sysctl_pkg::IDX_REV);

    // R6
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && {1'b0, req_addr} >= BANK_END) |=> (rd_data == '0 && err_pulse));

    // R6
    err_has_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(wr_en || rd_en));

    // R5
    ro_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req_addr == A_ID0) |=> err_pulse);

    // R4
    rev_alias_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && req_addr == A_REV) |=> !err_pulse);

    // R7
    viol_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_viol |-> ($past(wr_en) && $past(req_addr) != '0 &&
                       {1'b0, $past(req_addr)} < WIN_END));

    // R2
    key_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req_addr == '0) |=> !lock_viol);

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind sysctl_regbank sysctl_regbank_chk #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .LOCK_END(LOCK_END)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_addr  (req_addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .err_pulse (err_pulse),
    .lock_viol (lock_viol)
);

// File: tb/sysctl_regbank_test.sv
`timescale 1ns/1ps
module sysctl_regbank_test;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [6:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        err;
        logic        lv;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 40;
    // Fields: wr, rd, addr, data, expected read, expected err, expected viol, requirement
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,7'd0,  32'h0,        32'h0,        1'b0,1'b0,4'd1}, // R1 key bit 0
        '{1'b0,1'b1,7'd16, 32'h0,        32'h1234ABCD, 1'b0,1'b0,4'd1}, // R1
        '{1'b0,1'b1,7'd17, 32'h0,        32'h88884444, 1'b0,1'b0,4'd1}, // R1
        '{1'b0,1'b1,7'd20, 32'h0,        32'h00001903, 1'b0,1'b0,4'd1}, // R1
        '{1'b0,1'b1,7'd21, 32'h0,        32'h0000007B, 1'b0,1'b0,4'd1}, // R1
        '{1'b0,1'b1,7'd2,  32'h0,        32'h0A0B0001, 1'b0,1'b0,4'd1}, // R1
        '{1'b0,1'b1,7'd1,  32'h0,        32'h0,        1'b0,1'b0,4'd1}, // R1
        '{1'b1,1'b0,7'd30, 32'hAAAA5555, 32'h0,        1'b0,1'b1,4'd7}, // R7 closed
        '{1'b0,1'b1,7'd30, 32'h0,        32'hAAAA5555, 1'b0,1'b0,4'd7}, // R7 applied
        '{1'b1,1'b0,7'd0,  32'h1688A8A8, 32'h0,        1'b0,1'b0,4'd2}, // R2 open
        '{1'b0,1'b1,7'd0,  32'h0,        32'h1,        1'b0,1'b0,4'd2}, // R2
        '{1'b1,1'b0,7'd31, 32'h12345678, 32'h0,        1'b0,1'b0,4'd7}, // R7 open
        '{1'b0,1'b1,7'd31, 32'h0,        32'h12345678, 1'b0,1'b0,4'd8}, // R8
        '{1'b1,1'b0,7'd1,  32'h000000F0, 32'h0,        1'b0,1'b0,4'd3}, // R3
        '{1'b1,1'b0,7'd1,  32'h00000F00, 32'h0,        1'b0,1'b0,4'd3}, // R3
        '{1'b0,1'b1,7'd1,  32'h0,        32'h00000FF0, 1'b0,1'b0,4'd3}, // R3
        '{1'b1,1'b0,7'd2,  32'h00000030, 32'h0,        1'b0,1'b0,4'd4}, // R4
        '{1'b0,1'b1,7'd1,  32'h0,        32'h00000FC0, 1'b0,1'b0,4'd4}, // R4
        '{1'b0,1'b1,7'd2,  32'h0,        32'h0A0B0001, 1'b0,1'b0,4'd4}, // R4
        '{1'b1,1'b0,7'd16, 32'h0,        32'h0,        1'b1,1'b0,4'd5}, // R5
        '{1'b0,1'b1,7'd16, 32'h0,        32'h1234ABCD, 1'b0,1'b0,4'd5}, // R5
        '{1'b1,1'b0,7'd7,  32'h0000FFFF, 32'h0,        1'b1,1'b0,4'd5}, // R5
        '{1'b0,1'b1,7'd7,  32'h0,        32'h0,        1'b0,1'b0,4'd5}, // R5
        '{1'b1,1'b0,7'd14, 32'h1,        32'h0,        1'b1,1'b0,4'd5}, // R5
        '{1'b0,1'b1,7'd14, 32'h0,        32'h0,        1'b0,1'b0,4'd5}, // R5
        '{1'b1,1'b0,7'd100,32'h5,        32'h0,        1'b1,1'b0,4'd6}, // R6
        '{1'b0,1'b1,7'd100,32'h0,        32'h0,        1'b1,1'b0,4'd6}, // R6
        '{1'b1,1'b0,7'd95, 32'h1,        32'h0,        1'b0,1'b0,4'd6}, // R6 last word
        '{1'b0,1'b1,7'd95, 32'h0,        32'h1,        1'b0,1'b0,4'd6}, // R6
        '{1'b0,1'b1,7'd96, 32'h0,        32'h0,        1'b1,1'b0,4'd6}, // R6 first beyond
        '{1'b1,1'b0,7'd0,  32'h1688A8A9, 32'h0,        1'b0,1'b0,4'd2}, // R2 wrong key
        '{1'b0,1'b1,7'd0,  32'h0,        32'h0,        1'b0,1'b0,4'd2}, // R2
        '{1'b1,1'b0,7'd70, 32'hCAFEF00D, 32'h0,        1'b0,1'b0,4'd7}, // R7 above window
        '{1'b0,1'b1,7'd70, 32'h0,        32'hCAFEF00D, 1'b0,1'b0,4'd8}, // R8
        '{1'b1,1'b0,7'd63, 32'h3,        32'h0,        1'b0,1'b1,4'd7}, // R7 window edge
        '{1'b1,1'b0,7'd0,  32'h1688A8A8, 32'h0,        1'b0,1'b0,4'd7}, // R7 key word
        '{1'b0,1'b1,7'd63, 32'h0,        32'h3,        1'b0,1'b0,4'd7}, // R7
        '{1'b1,1'b0,7'd17, 32'hFFFFFFFF, 32'h0,        1'b1,1'b0,4'd5}, // R5
        '{1'b0,1'b1,7'd17, 32'h0,        32'h88884444, 1'b0,1'b0,4'd5}, // R5
        '{1'b0,1'b1,7'd0,  32'h0,        32'h1,        1'b0,1'b0,4'd2}  // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  req_addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        err_pulse;
    logic        lock_viol;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_regbank uut (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .err_pulse(err_pulse), .lock_viol(lock_viol)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one access at a falling edge; outputs are checked one cycle later.
    task automatic access(logic w, logic r, logic [6:0] a, logic [31:0] d);
        wr_en = w; rd_en = r; req_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state of the pulse outputs
        check("R1 err after reset", {31'b0, err_pulse}, 32'h0);
        check("R1 viol after reset", {31'b0, lock_viol}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].data);
            if (VECS[i].rd)
                check($sformatf("R%0d rd_data vec%0d", VECS[i].req, i), rd_data, VECS[i].exp);
            check($sformatf("R%0d err vec%0d", VECS[i].req, i), {31'b0, err_pulse}, {31'b0, VECS[i].err});
            check($sformatf("R%0d viol vec%0d", VECS[i].req, i), {31'b0, lock_viol}, {31'b0, VECS[i].lv});
        end

        // R9: read and write in one cycle return the old word
        access(1'b1, 1'b0, 7'd40, 32'h11112222);
        access(1'b1, 1'b1, 7'd40, 32'h33334444);
        check("R9 read-during-write old", rd_data, 32'h11112222);
        access(1'b0, 1'b1, 7'd40, 32'h0);
        check("R9 read-after-write new", rd_data, 32'h33334444);
        // R9: idle cycles hold read data
        @(posedge clk); @(negedge clk);
        check("R9 hold while idle", rd_data, 32'h33334444);

        // R1: reset mid-run restores defaults and closes the bank
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 1'b1, 7'd40, 32'h0);
        check("R1 plain word after reset", rd_data, 32'h0);
        access(1'b0, 1'b1, 7'd1, 32'h0);
        check("R1 strap after reset", rd_data, 32'h0);
        access(1'b0, 1'b1, 7'd0, 32'h0);
        check("R1 key bit after reset", rd_data, 32'h0);
        access(1'b1, 1'b0, 7'd5, 32'h0);
        check("R5 scratch write err", {31'b0, err_pulse}, 32'h1);
        check("R7 closed after reset", {31'b0, lock_viol}, 32'h1);

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

endmodule